// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter stage, four bits wide by default, that wraps modulo 2^W. On every rising clock edge it does one of four things: it loads a parallel data word, counts up, counts down, or keeps its value. Loading takes priority over counting and ignores both count enables. Counting needs both active-low enables (a parallel enable and a trickle enable) to be low. A direction input picks increment or decrement.

An active-low terminal-count output is decoded combinationally from the stored count, the direction input and the trickle enable. It goes low when the trickle enable is low and the count sits at its last value for the current direction: all ones when counting up, all zeros when counting down. Wider counters are built by wiring each stage's terminal-count output to the trickle enable of the next stage. All stages share the clock, the direction, the parallel enable and the load control, so the whole chain steps on one edge with no ripple and no added gating. A synchronous active-high reset clears the count and is meant for start-up.

Top module: `ctr_updown_stage`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 on that edge, whatever the other inputs are.
- R2: With `rst` low and `load_n` low at a rising edge, `count` takes the value of `din` on that edge, whatever `en_par_n`, `en_trk_n` and `dir_up` are.
- R3: With `load_n` high, `en_par_n` low, `en_trk_n` low and `dir_up` = 1, the count goes up by one per edge and wraps from all ones to 0.
- R4: With `load_n` high, `en_par_n` low, `en_trk_n` low and `dir_up` = 0, the count goes down by one per edge and wraps from 0 to all ones.
- R5: With `load_n` high and `en_par_n` high or `en_trk_n` high, the count keeps its value.
- R6: `tc_n` is 0 exactly when `en_trk_n` is 0 and either `dir_up` = 1 with the count all ones, or `dir_up` = 0 with the count all zeros. Otherwise it is 1.
- R7: `tc_n` does not depend on `en_par_n`.
- R8: `tc_n` is not registered. It follows changes on `dir_up`, `en_trk_n` and `count` within the same cycle, with no clock edge between them.
- R9: When stage k's `tc_n` drives stage k+1's `en_trk_n`, and all stages share `clk`, `dir_up`, `load_n` and `en_par_n`, the chain behaves as one counter of the combined width. It carries and borrows across stage boundaries on the same edge, and its top-stage `tc_n` marks the terminal value of the whole chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the count |
| dir_up | input | 1 | Count direction: 1 increments, 0 decrements |
| load_n | input | 1 | Parallel load, active low; highest priority after reset |
| en_par_n | input | 1 | Parallel count enable, active low; gates counting only |
| en_trk_n | input | 1 | Trickle count enable, active low; gates counting and `tc_n` |
| din | input | W | Parallel load value |
| count | output | W | Registered count value |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
The bench chains three stages into a 12-bit counter and drives it across the 0x0FF/0x100 boundary and through both full-scale wraps. A design that did not carry through the trickle path would leave the upper nibbles stuck or step them one cycle late. Loads are applied with both enables high, to catch a design that lets the enables block loading. Holds are forced by each enable on its own: a design that needs only one enable low to count would advance when it should hold. The terminal-count output is sampled between edges, just after the direction, trickle enable or count changes, and again while the parallel enable toggles. A registered or parallel-gated decode would then show the wrong level in that cycle.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // Operation chosen for the next rising edge (reset handled separately).
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } ctr_op_t;

endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
  import ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    en_par_n,
  input  logic    en_trk_n,
  input  logic    dir_up,
  output ctr_op_t op
);

  logic cnt_ok;

  // Both active-low enables must be asserted for a count step.
  assign cnt_ok = ~en_par_n & ~en_trk_n;

  always_comb begin
    if (!load_n) begin
      op = OP_LOAD;          // load ignores both enables
    end else if (cnt_ok) begin
      op = dir_up ? OP_INC : OP_DEC;
    end else begin
      op = OP_HOLD;
    end
  end

endmodule

// File: rtl/ctr_next_val.sv
module ctr_next_val
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  ctr_op_t      op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_INC:  nxt = cur + ONE;   // natural wrap modulo 2^W
      OP_DEC:  nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/ctr_term_dec.sv
module ctr_term_dec #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir_up,
  input  logic         en_trk_n,
  output logic         tc_n
);

  localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
  localparam logic [W-1:0] BOT_VAL = '0;

  logic at_end;

  // Last value in the current direction.
  assign at_end = dir_up ? (cur == TOP_VAL) : (cur == BOT_VAL);
  assign tc_n   = ~(at_end & ~en_trk_n);

endmodule

// File: rtl/ctr_updown_stage.sv
module ctr_updown_stage
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_up,
  input  logic         load_n,
  input  logic         en_par_n,
  input  logic         en_trk_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] count,
  output logic         tc_n
);

  ctr_op_t      op;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  ctr_mode_sel u_mode (
    .load_n   (load_n),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .dir_up   (dir_up),
    .op       (op)
  );

  ctr_next_val #(.W(W)) u_next (
    .op  (op),
    .cur (cnt_q),
    .din (din),
    .nxt (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  ctr_term_dec #(.W(W)) u_term (
    .cur      (cnt_q),
    .dir_up   (dir_up),
    .en_trk_n (en_trk_n),
    .tc_n     (tc_n)
  );

  assign count = cnt_q;

endmodule

// File: rtl/ctr_updown_chk.sv
module ctr_updown_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         dir_up,
  input logic         load_n,
  input logic         en_par_n,
  input logic         en_trk_n,
  input logic [W-1:0] din,
  input logic [W-1:0] count,
  input logic         tc_n
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> count == '0);

  p_load_any_enable_r2: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> count == $past(din));

  p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_par_n && !en_trk_n && dir_up) |=> count == W'($past(count) + 1'b1));

  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_par_n && !en_trk_n && !dir_up) |=> count == W'($past(count) - 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (load_n && (en_par_n || en_trk_n)) |=> $stable(count));

  p_tc_needs_trickle_r6: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> !en_trk_n);

  p_tc_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> (dir_up ? (&count) : (count == '0)));

endmodule

bind ctr_updown_stage ctr_updown_chk #(.W(W)) u_chk (.*);

// File: tb/sim_ctr_updown_stage.sv
`timescale 1ns/1ps
module sim_ctr_updown_stage;

  localparam int W  = 4;
  localparam int CW = 3 * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          dir_up;
  logic          load_n;
  logic          en_par_n;
  logic          en_trk0_n;
  logic [CW-1:0] din;
  logic [W-1:0]  c0, c1, c2;
  logic          tc0_n, tc1_n, tc2_n;

  always #2.5 clk = ~clk;

  ctr_updown_stage #(.W(W)) u0 (
    .clk(clk), .rst(rst), .dir_up(dir_up), .load_n(load_n),
    .en_par_n(en_par_n), .en_trk_n(en_trk0_n), .din(din[W-1:0]),
    .count(c0), .tc_n(tc0_n));
  ctr_updown_stage #(.W(W)) u1 (
    .clk(clk), .rst(rst), .dir_up(dir_up), .load_n(load_n),
    .en_par_n(en_par_n), .en_trk_n(tc0_n), .din(din[2*W-1:W]),
    .count(c1), .tc_n(tc1_n));
  ctr_updown_stage #(.W(W)) u2 (
    .clk(clk), .rst(rst), .dir_up(dir_up), .load_n(load_n),
    .en_par_n(en_par_n), .en_trk_n(tc1_n), .din(din[3*W-1:2*W]),
    .count(c2), .tc_n(tc2_n));

  typedef struct {
    logic [CW-1:0] val;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            n_chk  = 0;
  int            n_fail = 0;
  logic [CW-1:0] model  = '0;
  bit            done   = 1'b0;

  // Monitor: compares the chained count shortly after each edge.
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if ({c2, c1, c0} !== e.val) begin
        n_fail++;
        $display("FAIL %s count actual=%03h expected=%03h", e.tag, {c2, c1, c0}, e.val);
      end
    end
  end

  task automatic check_tc(string tag);
    logic t0_exp, tall_exp;
    t0_exp   = ~(~en_trk0_n & (dir_up ? (model[W-1:0] == '1) : (model[W-1:0] == '0)));
    tall_exp = ~(~en_trk0_n & (dir_up ? (model == '1) : (model == '0)));
    n_chk += 2;
    if (tc0_n !== t0_exp) begin
      n_fail++;
      $display("FAIL %s stage tc_n actual=%b expected=%b", tag, tc0_n, t0_exp);
    end
    if (tc2_n !== tall_exp) begin
      n_fail++;
      $display("FAIL %s chain tc_n actual=%b expected=%b", tag, tc2_n, tall_exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the combinational
  // terminal count, and queues the expected count after the edge.
  task automatic drive(bit r, bit ld_n, bit up, bit ep_n, bit et_n,
                       logic [CW-1:0] d, string tag);
    exp_t e;
    @(negedge clk);
    rst = r; load_n = ld_n; dir_up = up; en_par_n = ep_n; en_trk0_n = et_n; din = d;
    #1;
    if (!r) check_tc(tag);
    if (r)            model = '0;
    else if (!ld_n)   model = d;
    else if (!ep_n && !et_n) model = up ? model + 1'b1 : model - 1'b1;
    e.val = model;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    rst = 1'b1; load_n = 1'b1; dir_up = 1'b1; en_par_n = 1'b1; en_trk0_n = 1'b1; din = '0;
    // R1: reset clears, even with load requested
    drive(1, 1, 1, 0, 0, 12'h000, "R1");
    drive(1, 0, 1, 0, 0, 12'hABC, "R1");
    // R2: load with both enables inactive, and with both active
    drive(0, 0, 0, 1, 1, 12'h7F5, "R2");
    drive(0, 0, 1, 0, 0, 12'h0FD, "R2");
    // R3/R9: count up across stage boundary
    for (int i = 0; i < 5; i++) drive(0, 1, 1, 0, 0, 12'h000, "R3_R9");
    // R3: full-scale wrap
    drive(0, 0, 1, 1, 1, 12'hFFE, "R2");
    for (int i = 0; i < 3; i++) drive(0, 1, 1, 0, 0, 12'h000, "R3");
    // R4/R9: count down across boundary
    drive(0, 0, 0, 1, 1, 12'h101, "R2");
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 0, 12'h000, "R4_R9");
    drive(0, 0, 0, 1, 1, 12'h001, "R2");
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, 0, 12'h000, "R4");
    // R5: hold by each enable alone
    drive(0, 1, 1, 1, 0, 12'h000, "R5");
    drive(0, 1, 0, 1, 0, 12'h000, "R5");
    drive(0, 1, 1, 0, 1, 12'h000, "R5");
    drive(0, 1, 0, 0, 1, 12'h000, "R5");
    // R7: terminal count unaffected by parallel enable
    drive(0, 0, 1, 1, 1, 12'hFFF, "R2");
    drive(0, 1, 1, 1, 0, 12'h000, "R7");
    drive(0, 1, 1, 1, 0, 12'h000, "R7");
    drive(0, 1, 1, 1, 0, 12'h000, "R7");
    // R8: direction and trickle change the output within the cycle
    drive(0, 1, 0, 1, 0, 12'h000, "R8");
    drive(0, 1, 1, 1, 1, 12'h000, "R8");
    drive(0, 1, 1, 1, 0, 12'h000, "R8");
    drive(0, 0, 0, 1, 1, 12'h000, "R2");
    drive(0, 1, 0, 1, 0, 12'h000, "R8");
    drive(0, 1, 1, 1, 0, 12'h000, "R8");
    // R6/R9: long runs through many terminal values
    for (int i = 0; i < 300; i++) drive(0, 1, 0, 0, 0, 12'h000, "R6_R9");
    for (int i = 0; i < 600; i++) drive(0, 1, 1, (i % 7) == 3, (i % 11) == 5, 12'h000, "R6_R9");
    drive(0, 1, 1, 1, 1, 12'h000, "R5");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule